// File: doc/BRIEF.md
# Serial Flash Probe and Unlock Sequencer

This block runs a short bring-up routine against an SPI NOR flash device after a start pulse. It drives a byte-level SPI master: it lowers an active-low chip select, presents one byte together with a one-cycle send strobe, and waits for the engine to return the byte it clocked in before it sends another. The routine has two parts. First it reads the identification bytes of the device and checks them. If the device is accepted, it then clears the global write protection that the device applies at power-up.

In the identification frame the block sends opcode 0x9F and then three filler bytes. The three bytes returned during the filler bytes are the manufacturer, memory-type and capacity codes. The device is accepted only if the manufacturer and memory type match the expected values and the capacity code is one of the two known densities. On acceptance the block loads the sector and page counts and the size shifts. It then sends three one-byte command frames and raises done. On rejection it raises an error flag and sends nothing more.

Top module: `flash_probe_seq`

## Requirements
- R1: After reset, cs_no is 1, xfer_o is 0, and busy_o, done_o, err_o and all geometry outputs are 0.
- R2: A start pulse while idle opens exactly one chip-select frame. In it xfer_o sends 0x9F and then 0xA5 three times. xfer_o is high only while cs_no is 0, and never in the cycle in which cs_no falls.
- R3: After each xfer_o pulse, the next pulse waits until rx_valid_i has returned the byte, whatever the engine's latency.
- R4: The bytes received during the three filler bytes are the manufacturer, memory-type and capacity codes, in that order. The device is rejected unless manufacturer is 0xBF and memory type is 0x25. On rejection err_o rises and no further frame is sent.
- R5: Capacity code 0x43 gives 2048 sectors and 32768 pages. Code 0x42 gives 1024 sectors and 16384 pages. Any other code is a rejection.
- R6: On acceptance, sect_shift_o reads 12 (4096-byte sectors) and page_shift_o reads 8 (256-byte pages).
- R7: After acceptance the block sends three one-byte frames in this order: 0x06, then 0x98, then 0x04. It then raises done_o and drops busy_o.
- R8: cs_no is high for at least one cycle between any two consecutive frames.
- R9: done_o and err_o stay at their values until the next accepted start. A start pulse while busy_o is 1 has no effect on the byte sequence.
- R10: After a rejection, the sector and page count outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to run the probe |
| rx_valid_i | input | 1 | Engine has finished the current byte |
| rx_byte_i | input | 8 | Byte received during the current transfer |
| cs_no | output | 1 | Device chip select, active low |
| xfer_o | output | 1 | One-cycle strobe to send tx_byte_o |
| tx_byte_o | output | 8 | Byte to send; valid with xfer_o |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Device accepted and unlocked (sticky) |
| err_o | output | 1 | Device rejected (sticky) |
| sect_cnt_o | output | 12 | Number of erase sectors |
| page_cnt_o | output | 16 | Number of program pages |
| sect_shift_o | output | 4 | log2 of the sector size in bytes |
| page_shift_o | output | 4 | log2 of the page size in bytes |

## Verification
The embedded assertions check on every cycle the rules that are local in time. A strobe occurs only inside a frame and never in the setup cycle. Two strobes are never back to back. done and err are never high together, they hold until a start, and the geometry outputs agree with the outcome. The bench scenarios check the rest: the exact byte order across frames, how bytes are grouped into chip-select frames, the decoding of each capacity code, the rejection paths, and whether a start pulse during a run is ignored. These depend on the device's replies and on how many frames are counted, which a single-cycle property cannot see.

// File: rtl/fp_pkg.sv
package fp_pkg;
  localparam logic [7:0] OP_READ_ID  = 8'h9F;
  localparam logic [7:0] OP_FILLER   = 8'hA5;
  localparam logic [7:0] OP_WR_EN    = 8'h06;
  localparam logic [7:0] OP_UNPROT   = 8'h98;
  localparam logic [7:0] OP_WR_DIS   = 8'h04;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_SEND,
    ST_WAIT,
    ST_GAP,
    ST_CHECK
  } fp_state_e;
endpackage

// File: rtl/fp_cmd_sel.sv
module fp_cmd_sel
  import fp_pkg::*;
#(
  parameter int ID_BYTES = 3,
  parameter int IDX_W    = $clog2(ID_BYTES + 1)
) (
  input  logic [1:0]       frame_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       byte_o,
  output logic             last_o
);
  always_comb begin
    byte_o = OP_FILLER;
    last_o = 1'b1;
    case (frame_i)
      2'd0: begin
        byte_o = (idx_i == '0) ? OP_READ_ID : OP_FILLER;
        last_o = (idx_i == IDX_W'(ID_BYTES));
      end
      2'd1: byte_o = OP_WR_EN;
      2'd2: byte_o = OP_UNPROT;
      default: byte_o = OP_WR_DIS;
    endcase
  end
endmodule

// File: rtl/fp_id_decode.sv
module fp_id_decode #(
  parameter logic [7:0] MFR_CODE   = 8'hBF,
  parameter logic [7:0] TYPE_CODE  = 8'h25,
  parameter logic [7:0] CAP_LARGE  = 8'h43,
  parameter logic [7:0] CAP_SMALL  = 8'h42,
  parameter int         SECT_LARGE = 2048,
  parameter int         SECT_SMALL = 1024,
  parameter int         SECT_SHIFT = 12,
  parameter int         PAGE_SHIFT = 8,
  parameter int         SECT_W     = 12,
  parameter int         PAGE_W     = 16
) (
  input  logic [7:0]        mfr_i,
  input  logic [7:0]        type_i,
  input  logic [7:0]        cap_i,
  output logic              ok_o,
  output logic [SECT_W-1:0] sect_o,
  output logic [PAGE_W-1:0] page_o
);
  localparam int PAGES_PER_SECT_LOG = SECT_SHIFT - PAGE_SHIFT;

  logic vendor_ok;
  assign vendor_ok = (mfr_i == MFR_CODE) && (type_i == TYPE_CODE);

  always_comb begin
    ok_o   = 1'b0;
    sect_o = '0;
    if (vendor_ok) begin
      if (cap_i == CAP_LARGE) begin
        ok_o   = 1'b1;
        sect_o = SECT_W'(SECT_LARGE);
      end else if (cap_i == CAP_SMALL) begin
        ok_o   = 1'b1;
        sect_o = SECT_W'(SECT_SMALL);
      end
    end
    page_o = PAGE_W'(sect_o) << PAGES_PER_SECT_LOG;
  end
endmodule

// File: rtl/flash_probe_seq.sv
module flash_probe_seq
  import fp_pkg::*;
#(
  parameter logic [7:0] MFR_CODE   = 8'hBF,
  parameter logic [7:0] TYPE_CODE  = 8'h25,
  parameter int         SECT_SHIFT = 12,
  parameter int         PAGE_SHIFT = 8,
  parameter int         SECT_W     = 12,
  parameter int         PAGE_W     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_byte_i,
  output logic              cs_no,
  output logic              xfer_o,
  output logic [7:0]        tx_byte_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [SECT_W-1:0] sect_cnt_o,
  output logic [PAGE_W-1:0] page_cnt_o,
  output logic [3:0]        sect_shift_o,
  output logic [3:0]        page_shift_o
);
  localparam int ID_BYTES = 3;
  localparam int IDX_W    = $clog2(ID_BYTES + 1);
  localparam logic [1:0] LAST_FRAME = 2'd3;

  fp_state_e        st_q;
  logic [1:0]       frame_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       id_q [ID_BYTES];
  logic             last_byte;
  logic             id_ok;
  logic [SECT_W-1:0] dec_sect;
  logic [PAGE_W-1:0] dec_page;
  logic             cap_en;

  fp_cmd_sel #(.ID_BYTES(ID_BYTES), .IDX_W(IDX_W)) u_cmd (
    .frame_i(frame_q),
    .idx_i  (idx_q),
    .byte_o (tx_byte_o),
    .last_o (last_byte)
  );

  fp_id_decode #(
    .MFR_CODE  (MFR_CODE),
    .TYPE_CODE (TYPE_CODE),
    .SECT_SHIFT(SECT_SHIFT),
    .PAGE_SHIFT(PAGE_SHIFT),
    .SECT_W    (SECT_W),
    .PAGE_W    (PAGE_W)
  ) u_dec (
    .mfr_i (id_q[0]),
    .type_i(id_q[1]),
    .cap_i (id_q[2]),
    .ok_o  (id_ok),
    .sect_o(dec_sect),
    .page_o(dec_page)
  );

  assign cap_en = (st_q == ST_WAIT) && rx_valid_i && (frame_q == 2'd0);

  // byte 0 of the ID frame is the opcode; reply bytes land at idx 1..ID_BYTES
  for (genvar g = 0; g < ID_BYTES; g++) begin : g_id
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 id_q[g] <= '0;
      else if (cap_en && idx_q == IDX_W'(g + 1))   id_q[g] <= rx_byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      frame_q      <= '0;
      idx_q        <= '0;
      done_o       <= 1'b0;
      err_o        <= 1'b0;
      sect_cnt_o   <= '0;
      page_cnt_o   <= '0;
      sect_shift_o <= '0;
      page_shift_o <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          frame_q      <= '0;
          idx_q        <= '0;
          done_o       <= 1'b0;
          err_o        <= 1'b0;
          sect_cnt_o   <= '0;
          page_cnt_o   <= '0;
          sect_shift_o <= '0;
          page_shift_o <= '0;
          st_q         <= ST_SEL;
        end
        ST_SEL:  st_q <= ST_SEND;
        ST_SEND: st_q <= ST_WAIT;
        ST_WAIT: if (rx_valid_i) begin
          if (last_byte) st_q <= ST_GAP;
          else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_SEND;
          end
        end
        ST_GAP: begin
          if (frame_q == 2'd0) st_q <= ST_CHECK;
          else if (frame_q == LAST_FRAME) begin
            done_o <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            frame_q <= frame_q + 1'b1;
            idx_q   <= '0;
            st_q    <= ST_SEL;
          end
        end
        ST_CHECK: begin
          if (id_ok) begin
            sect_cnt_o   <= dec_sect;
            page_cnt_o   <= dec_page;
            sect_shift_o <= 4'(SECT_SHIFT);
            page_shift_o <= 4'(PAGE_SHIFT);
            frame_q      <= 2'd1;
            idx_q        <= '0;
            st_q         <= ST_SEL;
          end else begin
            err_o <= 1'b1;
            st_q  <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no  = !(st_q == ST_SEL || st_q == ST_SEND || st_q == ST_WAIT);
  assign xfer_o = (st_q == ST_SEND);
  assign busy_o = (st_q != ST_IDLE);

  a_r2_strobe_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> !cs_no);
  a_r2_no_strobe_on_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> !xfer_o);
  a_r3_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |=> !xfer_o);
  a_r9_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);
  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !start_i |=> err_o);
  a_r4_outcome_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  a_r4_silent_after_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !xfer_o && cs_no);
  a_r10_no_geometry_on_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> sect_cnt_o == '0 && page_cnt_o == '0);
  a_r6_shifts_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> sect_shift_o == 4'(SECT_SHIFT) && page_shift_o == 4'(PAGE_SHIFT));
endmodule

// File: tb/sim_flash_probe_seq.sv
module sim_flash_probe_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic cs_no, xfer, busy, done, err;
  logic [7:0] tx_byte;
  logic [11:0] sect_cnt;
  logic [15:0] page_cnt;
  logic [3:0] sect_shift, page_shift;

  int checks = 0;
  int errors = 0;
  int lat = 2;
  int cs_falls = 0;
  logic prev_cs = 1'b1;

  int         exp_frame[$];
  logic [7:0] exp_byte[$];
  string      exp_tag[$];
  logic [7:0] resp_q[$];

  always #4 clk = ~clk;

  flash_probe_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .cs_no(cs_no), .xfer_o(xfer), .tx_byte_o(tx_byte),
    .busy_o(busy), .done_o(done), .err_o(err),
    .sect_cnt_o(sect_cnt), .page_cnt_o(page_cnt),
    .sect_shift_o(sect_shift), .page_shift_o(page_shift)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: counts frames and pops the scoreboard on each strobe
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !cs_no) cs_falls++;
      prev_cs = cs_no;
      if (xfer) begin
        chk(!cs_no, "R2", "strobe outside frame", 1, 0);
        if (exp_byte.size() == 0) begin
          chk(1'b0, "R7", "unexpected byte", int'(tx_byte), -1);
        end else begin
          int f;
          logic [7:0] b;
          string t;
          f = exp_frame.pop_front();
          b = exp_byte.pop_front();
          t = exp_tag.pop_front();
          chk(tx_byte == b, t, "tx byte", int'(tx_byte), int'(b));
          chk(cs_falls == f, "R8", "frame index", cs_falls, f);
        end
      end
    end
  end

  // SPI engine model with programmable latency
  initial begin
    @(negedge clk);
    forever begin
      if (rst_n && xfer) begin
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          if (xfer) chk(1'b0, "R3", "strobe before reply", 1, 0);
        end
        rx_byte  = (resp_q.size() != 0) ? resp_q.pop_front() : 8'hFF;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  end

  task automatic push(input int f, input logic [7:0] b, input string t);
    exp_frame.push_back(f);
    exp_byte.push_back(b);
    exp_tag.push_back(t);
  endtask

  task automatic run_case(input logic [7:0] m, input logic [7:0] ty, input logic [7:0] c,
                          input int l, input bit poke, input bit ok_exp,
                          input int es, input int ep, input string gtag);
    int base;
    int n;
    base = cs_falls;
    lat  = l;
    push(base + 1, 8'h9F, "R2");
    push(base + 1, 8'hA5, "R2");
    push(base + 1, 8'hA5, "R2");
    push(base + 1, 8'hA5, "R2");
    resp_q.push_back(8'h00);
    resp_q.push_back(m);
    resp_q.push_back(ty);
    resp_q.push_back(c);
    if (ok_exp) begin
      push(base + 2, 8'h06, "R7");
      push(base + 3, 8'h98, "R7");
      push(base + 4, 8'h04, "R7");
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      chk(busy, "R9", "busy before poke", int'(busy), 1);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    n = 0;
    while (busy && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(!busy, "R7", "busy at end", int'(busy), 0);
    chk(done == ok_exp, ok_exp ? "R7" : "R4", "done", int'(done), int'(ok_exp));
    chk(err == !ok_exp, gtag, "err", int'(err), int'(!ok_exp));
    chk(sect_cnt == 12'(es), ok_exp ? "R5" : "R10", "sectors", int'(sect_cnt), es);
    chk(page_cnt == 16'(ep), ok_exp ? "R5" : "R10", "pages", int'(page_cnt), ep);
    if (ok_exp) begin
      chk(sect_shift == 4'd12, "R6", "sector shift", int'(sect_shift), 12);
      chk(page_shift == 4'd8, "R6", "page shift", int'(page_shift), 8);
    end
    chk(exp_byte.size() == 0, ok_exp ? "R7" : "R4", "bytes missing", exp_byte.size(), 0);
    exp_frame.delete(); exp_byte.delete(); exp_tag.delete(); resp_q.delete();
    repeat (20) @(negedge clk);
    chk(done == ok_exp && err == !ok_exp, "R9", "sticky outcome",
        int'({done, err}), int'({ok_exp, !ok_exp}));
    chk(cs_no && !xfer, "R9", "quiet while idle", int'({cs_no, xfer}), 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_no == 1'b1, "R1", "cs after reset", int'(cs_no), 1);
    chk(!xfer && !busy, "R1", "strobe/busy after reset", int'({xfer, busy}), 0);
    chk(!done && !err, "R1", "flags after reset", int'({done, err}), 0);
    chk(sect_cnt == 0 && page_cnt == 0, "R1", "geometry after reset",
        int'(sect_cnt), 0);

    run_case(8'hBF, 8'h25, 8'h43, 1, 1'b1, 1'b1, 2048, 32768, "R4");
    run_case(8'hBF, 8'h25, 8'h42, 4, 1'b0, 1'b1, 1024, 16384, "R5");
    run_case(8'hBE, 8'h25, 8'h43, 2, 1'b0, 1'b0, 0, 0, "R4");
    run_case(8'hBF, 8'h26, 8'h43, 3, 1'b0, 1'b0, 0, 0, "R4");
    run_case(8'hBF, 8'h25, 8'h41, 2, 1'b1, 1'b0, 0, 0, "R5");
    run_case(8'hBF, 8'h25, 8'h44, 1, 1'b0, 1'b0, 0, 0, "R5");
    run_case(8'hBF, 8'h25, 8'h43, 3, 1'b0, 1'b1, 2048, 32768, "R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule